// File: doc/BRIEF.md
# Windowed Vertical Sync Divider

This block sets field timing in a television deflection controller. Its clock runs at twice the line rate, so each count is half a line. It takes the separated vertical sync as a single input. A half-line counter restarts when a sync arrives inside the acceptance window that is currently active. If no sync is accepted, the counter restarts on its own at the window's last count, so the field timing keeps running with or without a signal.

A 4-bit saturating confidence counter chooses between two windows:

- **Wide search window:** used while acquiring a signal.
- **Narrow lock window:** used once the timing is trusted.

The counter has hysteresis. Lock needs a full score of 15. Search resumes only when the score falls below 10. The line standard (50 Hz or 60 Hz) is taken from the count at which each field restart happens.

The block also produces a gate that blanks the horizontal phase detector around vertical sync. In search mode this gate starts at the field restart. In lock mode it starts at the window opening, so it also covers the equalizing pulses.

Top module: `vsync_divider`

## Requirements
- R1: A synchronous active-high reset sets the divider count to 0 and the confidence to 0, and selects wide mode and 50 Hz. After reset, `field_start_o`, `is60_o`, `narrow_o` and `atf_o` are all 0.
- R2: In wide mode, a rising edge on `vsync_i` sampled at count 488 or later restarts the divider. A rising edge sampled before count 488 does not restart it.
- R3: In wide mode with no accepted sync, the divider restarts itself at count 722, giving a field of 723 counts.
- R4: At each restart, `is60_o` becomes 1 if the count is below 576 and 0 otherwise. It changes at no other time.
- R5: A sync inside the active window raises the confidence by 1, saturating at 15. Any other sync lowers it by 1, saturating at 0, and so does every self-restart. In wide mode, a sync counts as inside the window only if its count also lies in 522..528 or 622..628.
- R6: `narrow_o` rises on the clock edge at which the confidence reaches 15.
- R7: `narrow_o` falls on the clock edge at which the confidence drops below 10.
- R8: In narrow mode, only a sync sampled at a count from 522 to 528 (60 Hz) or from 622 to 628 (50 Hz) restarts the divider. A sync at any other count is ignored for timing.
- R9: In narrow mode with no accepted sync, the divider restarts itself at the window's closing count (528 or 628).
- R10: A sync that coincides with the closing count in narrow mode is treated as accepted, so the confidence rises rather than falls.
- R11: The anti-flutter gate `atf_o` ends at count 10 in 50 Hz mode and at count 12 in 60 Hz mode.
- R12: `atf_o` rises at the restart in wide mode. In narrow mode it rises at the window opening count and stays high through the restart.
- R13: `field_start_o` is a one-clock pulse in the cycle that follows a restart, while the count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-line clock (twice the line rate) |
| rst | input | 1 | Synchronous active-high reset |
| vsync_i | input | 1 | Separated vertical sync; its rising edge is the trigger |
| field_start_o | output | 1 | One-clock pulse at the start of each field |
| is60_o | output | 1 | 1 = 60 Hz standard, 0 = 50 Hz |
| narrow_o | output | 1 | 1 = narrow lock window active |
| atf_o | output | 1 | Anti-top-flutter gate for the phase detector |

## Verification
In narrow mode, an accepted sync and the self-restart at the window's closing count can fall on the same clock. The bench provokes this as follows:

1. It lowers the confidence to exactly 10 by letting five locked fields expire.
2. It then places a sync at count 528.

If the sync is wrongly treated as a miss, the confidence drops to 9 and `narrow_o` falls at once. If it is correctly accepted, lock survives that edge, and the bench then counts exactly two further missed fields before the drop to wide mode.

// File: rtl/vsync_divider.sv
module vsync_divider #(
  parameter int CW        = 10,
  parameter int FW        = 4,
  parameter int WIDE_LO   = 488,
  parameter int WIDE_HI   = 722,
  parameter int SPLIT     = 576,
  parameter int N60_LO    = 522,
  parameter int N60_HI    = 528,
  parameter int N50_LO    = 622,
  parameter int N50_HI    = 628,
  parameter int DROP      = 10,
  parameter int ATF50_END = 10,
  parameter int ATF60_END = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic vsync_i,
  output logic field_start_o,
  output logic is60_o,
  output logic narrow_o,
  output logic atf_o
);
  localparam logic [CW-1:0] L_WLO   = CW'(WIDE_LO);
  localparam logic [CW-1:0] L_WHI   = CW'(WIDE_HI);
  localparam logic [CW-1:0] L_SPLIT = CW'(SPLIT);
  localparam logic [CW-1:0] L_6LO   = CW'(N60_LO);
  localparam logic [CW-1:0] L_6HI   = CW'(N60_HI);
  localparam logic [CW-1:0] L_5LO   = CW'(N50_LO);
  localparam logic [CW-1:0] L_5HI   = CW'(N50_HI);
  localparam logic [CW-1:0] L_A5    = CW'(ATF50_END);
  localparam logic [CW-1:0] L_A6    = CW'(ATF60_END);
  localparam logic [FW-1:0] C_MAX   = '1;
  localparam logic [FW-1:0] C_DROP  = FW'(DROP);

  logic [CW-1:0] cnt;
  logic [FW-1:0] conf, conf_nxt;
  logic          vs_q, seen;

  wire sync_evt = vsync_i & ~vs_q;
  wire [CW-1:0] win_lo = is60_o ? L_6LO : L_5LO;
  wire [CW-1:0] win_hi = is60_o ? L_6HI : L_5HI;
  wire in_win  = (cnt >= win_lo) && (cnt <= win_hi);
  wire in_any  = ((cnt >= L_6LO) && (cnt <= L_6HI)) || ((cnt >= L_5LO) && (cnt <= L_5HI));
  wire accept  = sync_evt && (narrow_o ? in_win : (cnt >= L_WLO));
  wire expire  = narrow_o ? (cnt == win_hi) : (cnt == L_WHI);
  wire div_rst = accept || expire;
  wire good    = accept && (narrow_o || in_any);
  wire bad     = (sync_evt && !good) || (expire && !accept);

  always_comb begin
    conf_nxt = conf;
    if (good && conf != C_MAX)     conf_nxt = conf + 1'b1;
    else if (bad && conf != '0)    conf_nxt = conf - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      conf <= '0;
      vs_q <= 1'b0;
      seen <= 1'b0;
      is60_o <= 1'b0;
      narrow_o <= 1'b0;
      field_start_o <= 1'b0;
    end else begin
      vs_q <= vsync_i;
      conf <= conf_nxt;
      field_start_o <= div_rst;
      if (div_rst) begin
        cnt <= '0;
        seen <= 1'b1;
        is60_o <= (cnt < L_SPLIT);
      end else begin
        cnt <= cnt + 1'b1;
      end
      if (!narrow_o && conf_nxt == C_MAX)      narrow_o <= 1'b1;
      else if (narrow_o && conf_nxt < C_DROP)  narrow_o <= 1'b0;
    end
  end

  wire [CW-1:0] atf_end = is60_o ? L_A6 : L_A5;
  assign atf_o = (seen && cnt < atf_end) || (narrow_o && cnt >= win_lo);

  AST_LOCK_AT_MAX:   assert property (@(posedge clk) disable iff (rst) $rose(narrow_o) |-> conf == C_MAX);   // R6
  AST_UNLOCK_LOW:    assert property (@(posedge clk) disable iff (rst) $fell(narrow_o) |-> conf < C_DROP);   // R7
  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (rst) field_start_o |-> cnt == '0);          // R13
  AST_WIDE_BOUND:    assert property (@(posedge clk) disable iff (rst) !narrow_o |-> cnt <= L_WHI);          // R3
  AST_NARROW_BOUND:  assert property (@(posedge clk) disable iff (rst) narrow_o |-> cnt <= win_hi);          // R9
  AST_STD_HOLD:      assert property (@(posedge clk) disable iff (rst) !field_start_o |-> $stable(is60_o));  // R4
  AST_GATE_AT_START: assert property (@(posedge clk) disable iff (rst) field_start_o |-> atf_o);             // R12
endmodule

// File: tb/vsync_divider_test.sv
module vsync_divider_test;
  logic clk = 1'b0, rst = 1'b1, vsync = 1'b0;
  logic fs, is60, narrow, atf;
  int tests = 0, fails = 0;

  vsync_divider uut (.clk(clk), .rst(rst), .vsync_i(vsync), .field_start_o(fs),
                     .is60_o(is60), .narrow_o(narrow), .atf_o(atf));

  always #2 clk = ~clk;

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    vsync = 1'b0; rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic sync_at(int k);
    repeat (k) @(negedge clk);
    vsync = 1'b1;
    @(negedge clk);
    vsync = 1'b0;
  endtask

  task automatic pulse_now();
    vsync = 1'b1;
    @(negedge clk);
    vsync = 1'b0;
  endtask

  task automatic wait_len(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!fs && n < 2000);
  endtask

  task automatic t_reset();
    int n;
    do_reset();
    check("R1 field_start", fs, 0); check("R1 is60", is60, 0);
    check("R1 narrow", narrow, 0);  check("R1 atf", atf, 0);
    wait_len(n);
    check("R3 free-run length", n, 723);
    check("R12 atf at restart", atf, 1);
    check("R4 50Hz after 722", is60, 0);
    @(negedge clk); check("R13 pulse width", fs, 0);
    repeat (8) @(negedge clk); check("R11 atf cnt9 50Hz", atf, 1);
    @(negedge clk);            check("R11 atf cnt10 50Hz", atf, 0);
  endtask

  task automatic t_wide();
    int n;
    do_reset();
    sync_at(487); check("R2 sync at 487 ignored", fs, 0);
    wait_len(n);  check("R3 restart at 722", n, 235);
    sync_at(488); check("R2 sync at 488", fs, 1); check("R4 488 is 60", is60, 1);
    sync_at(575); check("R2 sync at 575", fs, 1); check("R4 575 is 60", is60, 1);
    sync_at(576); check("R2 sync at 576", fs, 1); check("R4 576 is 50", is60, 0);
  endtask

  task automatic t_lock60();
    int n;
    do_reset();
    for (int i = 0; i < 14; i++) sync_at(524);
    check("R6 not locked at 14", narrow, 0);
    sync_at(524);
    check("R6 locked at 15", narrow, 1); check("R4 60Hz", is60, 1);
    repeat (11) @(negedge clk); check("R11 atf cnt11 60Hz", atf, 1);
    @(negedge clk);             check("R11 atf cnt12 60Hz", atf, 0);
    repeat (509) @(negedge clk); check("R12 atf cnt521", atf, 0);
    @(negedge clk);              check("R12 atf cnt522", atf, 1);
    repeat (2) @(negedge clk);
    pulse_now(); check("R8 sync at 524 in lock", fs, 1);
    for (int i = 0; i < 4; i++) sync_at(524);
    sync_at(510); check("R8 sync at 510 ignored", fs, 0);
    wait_len(n);  check("R9 restart at 528", n, 18);
    for (int i = 0; i < 3; i++) begin
      wait_len(n); check("R9 locked field length", n, 529);
    end
    check("R5 saturated conf holds lock at 10", narrow, 1);
    wait_len(n); check("R7 unlock below 10", narrow, 0);
    wait_len(n); check("R3 back to wide length", n, 723);
  endtask

  task automatic t_coincide();
    int n;
    do_reset();
    for (int i = 0; i < 15; i++) sync_at(524);
    for (int i = 0; i < 5; i++) wait_len(n);
    check("R7 lock held at 10", narrow, 1);
    sync_at(528);
    check("R10 coincident restart", fs, 1);
    check("R10 coincident counted as hit", narrow, 1);
    wait_len(n); check("R10 one miss keeps lock", narrow, 1);
    wait_len(n); check("R10 second miss drops lock", narrow, 0);
  endtask

  task automatic t_lock50();
    int n;
    do_reset();
    for (int i = 0; i < 15; i++) sync_at(624);
    check("R6 locked 50Hz", narrow, 1); check("R4 50Hz", is60, 0);
    repeat (9) @(negedge clk); check("R11 atf cnt9 50Hz", atf, 1);
    @(negedge clk);            check("R11 atf cnt10 50Hz", atf, 0);
    repeat (611) @(negedge clk); check("R12 atf cnt621", atf, 0);
    @(negedge clk);              check("R12 atf cnt622", atf, 1);
    repeat (2) @(negedge clk);
    pulse_now(); check("R8 sync at 624", fs, 1);
    sync_at(560); check("R8 sync at 560 ignored", fs, 0);
    wait_len(n);  check("R9 restart at 628", n, 68);
  endtask

  task automatic t_offstd();
    int ok = 1;
    do_reset();
    for (int i = 0; i < 20; i++) begin
      sync_at(560);
      if (!fs) ok = 0;
    end
    check("R2 sync at 560 restarts", ok, 1);
    check("R5 off-standard builds no lock", narrow, 0);
  endtask

  initial begin
    t_reset();
    t_wide();
    t_lock60();
    t_coincide();
    t_lock50();
    t_offstd();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule